// File: doc/BRIEF.md
# Paged Configuration Register Bank

This block is the register file behind a byte-wide serial control port. Its address window is five bits wide, which is too small to cover every setting the datapath needs. The window is therefore widened by paging. One fixed slot, the top address 0x1F, holds a page selector and answers the same way whichever page is active. Every other slot is steered into the register set of the page that is currently selected. There are six pages, numbered 0 to 5.

A front end that is not part of this block turns serial frames into single-cycle transactions. Each transaction carries an address, write data and separate write and read strobes. The bank returns read data one clock later.

Every implemented register of every page also drives a flat parallel output bus. Downstream logic can therefore use settings from all pages at once, whichever page the software is currently looking at. The reset input is the only way to load the defaults. Nothing inside the block restores them at power-up.

Top module: `cfgbank_paged`

## Requirements
- R1: While `rst` is high at a clock edge, the page selector becomes 0, `rd_data` becomes 0x00, and every register of page p at index i takes the default value ((p << 4) | i) XOR 0x5A. No other event loads these defaults.
- R2: A write to address 0x1F with data in 0..5 selects that page for all later accesses. A read of 0x1F returns the current page number, zero-extended.
- R3: A write of a value from 6 to 255 to address 0x1F is ignored, and the page selected before it stays selected.
- R4: A write to an address in 0x00..0x0F changes only that index of the active page. The registers of every other page keep their values.
- R5: A read of an address in 0x00..0x0F returns the value of that index in the active page on `rd_data`, one clock after the cycle in which `rd_en` is sampled high.
- R6: Addresses 0x10..0x1E are unimplemented in every page. A read of one of them returns 0x00, and a write to one of them changes no register.
- R7: `cfg_flat` always shows every register of every page. Page p index i sits at bits [(p*16 + i)*8 +: 8].
- R8: `rd_data` holds its value in any cycle where `rd_en` is low.
- R9: When a read and a write target the same address in the same cycle, the read returns the value held before the write.
- R10: Asserting `rst` after registers have been written restores all defaults and page 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, loads all defaults |
| addr | input | 5 | Transaction address |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_data | output | 8 | Registered read data, valid the cycle after `rd_en` |
| cfg_flat | output | 768 | All registers of all pages, page-major and index-minor |

## Verification
The bench visits all six pages in turn. In each page it first reads every implemented index to check the defaults, then writes a value derived from the page and index, and compares the whole parallel bus against a model after each page. This separates a wrong page decode from a wrong index decode, because a write landing in the wrong page shows up as a mismatch in another page's field.

Every illegal selector value from 6 to 255 is written and then read back from 0x1F. This catches both a comparison that is off by one and a selector that is truncated instead of rejected.

Writes to the unimplemented slots, the hold of `rd_data` while `rd_en` is low, a read and a write to the same address in one cycle, and a reset issued mid-run each get their own pattern.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

  // Source selected for the next value of the read data register.
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PSEL = 2'd1,
    SRC_REG  = 2'd2
  } rd_src_e;

  // Reset value of a register: the page number in the upper nibble,
  // the index in the lower nibble, then XOR with a fixed pattern.
  function automatic logic [7:0] reg_default(input int unsigned pg, input int unsigned idx);
    logic [7:0] base;
    base = {pg[3:0], idx[3:0]};
    return base ^ 8'h5A;
  endfunction

endpackage

// File: rtl/cfgbank_page_sel.sv
module cfgbank_page_sel #(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 8,
  parameter int NUM_PAGES = 6,
  parameter int PAGE_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [PAGE_W-1:0] page_cur
);
  localparam logic [ADDR_W-1:0] PSEL_ADDR = {ADDR_W{1'b1}};

  logic hit;
  logic legal;

  assign hit   = wr_en && (addr == PSEL_ADDR);
  assign legal = (wr_data < DATA_W'(NUM_PAGES));

  always_ff @(posedge clk) begin
    if (rst) begin
      page_cur <= '0;
    end else if (hit && legal) begin
      page_cur <= wr_data[PAGE_W-1:0];
    end
  end
endmodule

// File: rtl/cfgbank_page.sv
module cfgbank_page #(
  parameter int PAGE_ID   = 0,
  parameter int DATA_W    = 8,
  parameter int REGS_IMPL = 16,
  parameter int IDX_W     = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            idx,
  input  logic [DATA_W-1:0]           wr_data,
  output logic [REGS_IMPL*DATA_W-1:0] regs_flat
);
  import cfgbank_pkg::*;

  for (genvar i = 0; i < REGS_IMPL; i++) begin : g_reg
    localparam logic [DATA_W-1:0] DFLT = DATA_W'(reg_default(PAGE_ID, i));
    logic [DATA_W-1:0] r;

    always_ff @(posedge clk) begin
      if (rst) begin
        r <= DFLT;
      end else if (wr_en && (idx == IDX_W'(i))) begin
        r <= wr_data;
      end
    end

    assign regs_flat[i*DATA_W +: DATA_W] = r;
  end
endmodule

// File: rtl/cfgbank_rdmux.sv
module cfgbank_rdmux #(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 8,
  parameter int NUM_PAGES = 6,
  parameter int REGS_IMPL = 16,
  parameter int PAGE_W    = 3,
  parameter int FLAT_W    = NUM_PAGES * REGS_IMPL * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W-1:0] page_cur,
  input  logic [FLAT_W-1:0] cfg_flat,
  output logic [DATA_W-1:0] rd_data
);
  import cfgbank_pkg::*;

  localparam logic [ADDR_W-1:0] PSEL_ADDR = {ADDR_W{1'b1}};

  rd_src_e           src;
  logic [DATA_W-1:0] reg_val;
  logic [DATA_W-1:0] nxt;

  always_comb begin
    if (addr == PSEL_ADDR) begin
      src = SRC_PSEL;
    end else if (addr < ADDR_W'(REGS_IMPL)) begin
      src = SRC_REG;
    end else begin
      src = SRC_NONE;
    end
  end

  always_comb begin
    reg_val = '0;
    for (int p = 0; p < NUM_PAGES; p++) begin
      for (int i = 0; i < REGS_IMPL; i++) begin
        if ((page_cur == PAGE_W'(p)) && (addr == ADDR_W'(i))) begin
          reg_val = cfg_flat[(p*REGS_IMPL + i)*DATA_W +: DATA_W];
        end
      end
    end
  end

  always_comb begin
    unique case (src)
      SRC_PSEL: nxt = DATA_W'(page_cur);
      SRC_REG:  nxt = reg_val;
      default:  nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= nxt;
    end
  end
endmodule

// File: rtl/cfgbank_paged.sv
module cfgbank_paged #(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 8,
  parameter int NUM_PAGES = 6,
  parameter int REGS_IMPL = 16
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [ADDR_W-1:0]                      addr,
  input  logic [DATA_W-1:0]                      wr_data,
  input  logic                                   wr_en,
  input  logic                                   rd_en,
  output logic [DATA_W-1:0]                      rd_data,
  output logic [NUM_PAGES*REGS_IMPL*DATA_W-1:0]  cfg_flat
);
  localparam int PAGE_W  = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
  localparam int IDX_W   = (REGS_IMPL > 1) ? $clog2(REGS_IMPL) : 1;
  localparam int PAGE_FW = REGS_IMPL * DATA_W;
  localparam int FLAT_W  = NUM_PAGES * PAGE_FW;

  logic [PAGE_W-1:0] page_cur;
  logic              reg_wr;
  logic [IDX_W-1:0]  idx;

  assign reg_wr = wr_en && (addr < ADDR_W'(REGS_IMPL));
  assign idx    = addr[IDX_W-1:0];

  cfgbank_page_sel #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PAGES(NUM_PAGES), .PAGE_W(PAGE_W)
  ) u_page_sel (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .page_cur(page_cur)
  );

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    logic page_wr;
    assign page_wr = reg_wr && (page_cur == PAGE_W'(p));

    cfgbank_page #(
      .PAGE_ID(p), .DATA_W(DATA_W), .REGS_IMPL(REGS_IMPL), .IDX_W(IDX_W)
    ) u_page (
      .clk(clk), .rst(rst), .wr_en(page_wr), .idx(idx), .wr_data(wr_data),
      .regs_flat(cfg_flat[p*PAGE_FW +: PAGE_FW])
    );
  end

  cfgbank_rdmux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PAGES(NUM_PAGES),
    .REGS_IMPL(REGS_IMPL), .PAGE_W(PAGE_W), .FLAT_W(FLAT_W)
  ) u_rdmux (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .page_cur(page_cur),
    .cfg_flat(cfg_flat), .rd_data(rd_data)
  );
endmodule

// File: rtl/cfgbank_paged_chk.sv
module cfgbank_paged_chk #(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 8,
  parameter int NUM_PAGES = 6,
  parameter int REGS_IMPL = 16,
  parameter int PAGE_W    = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic [PAGE_W-1:0] page_cur
);
  localparam logic [ADDR_W-1:0] PSEL_ADDR = {ADDR_W{1'b1}};

  // R2: a legal selector write takes effect on the next edge
  a_r2_page_update: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == PSEL_ADDR && wr_data < DATA_W'(NUM_PAGES))
      |=> (DATA_W'(page_cur) == $past(wr_data)));

  // R3: an illegal selector value leaves the page unchanged
  a_r3_bad_page_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == PSEL_ADDR && wr_data >= DATA_W'(NUM_PAGES))
      |=> $stable(page_cur));

  // R3: the selector never leaves the legal range
  a_r3_page_in_range: assert property (@(posedge clk) disable iff (rst)
    (page_cur < PAGE_W'(NUM_PAGES)));

  // R2: a read of the selector slot returns the page number
  a_r2_read_psel: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == PSEL_ADDR) |=> (rd_data == DATA_W'($past(page_cur))));

  // R6: unimplemented slots read as zero
  a_r6_unimpl_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr >= ADDR_W'(REGS_IMPL) && addr != PSEL_ADDR) |=> (rd_data == '0));

  // R8: the read data holds while no read is issued
  a_r8_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    (!rd_en) |=> $stable(rd_data));
endmodule

bind cfgbank_paged cfgbank_paged_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PAGES(NUM_PAGES),
  .REGS_IMPL(REGS_IMPL), .PAGE_W(PAGE_W)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
  .rd_en(rd_en), .rd_data(rd_data), .page_cur(page_cur)
);

// File: tb/cfgbank_paged_bench.sv
module cfgbank_paged_bench;
  localparam int CLK_P = 10;
  localparam int NP    = 6;
  localparam int NR    = 16;
  localparam int FW    = NP * NR * 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [4:0]    addr = '0;
  logic [7:0]    wr_data = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [7:0]    rd_data;
  logic [FW-1:0] cfg_flat;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  logic [7:0] model [NP][NR];
  int         mpage;

  always #(CLK_P/2) clk = ~clk;

  cfgbank_paged u_cfgbank_paged (
    .clk(clk), .rst(rst), .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
    .rd_en(rd_en), .rd_data(rd_data), .cfg_flat(cfg_flat)
  );

  function automatic logic [7:0] dflt(int p, int i);
    return 8'(((p & 15) << 4) | (i & 15)) ^ 8'h5A;
  endfunction

  function automatic logic [FW-1:0] model_flat();
    logic [FW-1:0] v;
    for (int p = 0; p < NP; p++)
      for (int i = 0; i < NR; i++)
        v[(p*NR + i)*8 +: 8] = model[p][i];
    return v;
  endfunction

  task automatic model_reset();
    for (int p = 0; p < NP; p++)
      for (int i = 0; i < NR; i++)
        model[p][i] = dflt(p, i);
    mpage = 0;
  endtask

  task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic chkflat(string req);
    logic [FW-1:0] e;
    e = model_flat();
    n_cmp++;
    if (cfg_flat !== e) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, cfg_flat, e);
    end
  endtask

  // One transaction; returns at the next negedge, after the capturing edge.
  task automatic xact(logic [4:0] a, logic [7:0] w, logic we, logic re);
    @(negedge clk);
    addr = a; wr_data = w; wr_en = we; rd_en = re;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  initial begin
    logic [7:0] hold;
    logic [7:0] v;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk8("R1 rd_data after reset", rd_data, 8'h00);
    chkflat("R1 defaults on cfg_flat");
    xact(5'h1F, 8'h00, 1'b0, 1'b1);
    chk8("R1 page after reset", rd_data, 8'h00);

    // R2 R4 R5 R7: page sweep
    for (int p = 0; p < NP; p++) begin
      xact(5'h1F, 8'(p), 1'b1, 1'b0);
      mpage = p;
      xact(5'h1F, 8'h00, 1'b0, 1'b1);
      chk8("R2 page readback", rd_data, 8'(p));
      for (int i = 0; i < NR; i++) begin
        xact(5'(i), 8'h00, 1'b0, 1'b1);
        chk8("R5 default read", rd_data, model[p][i]);
      end
      for (int i = 0; i < NR; i++) begin
        v = 8'((p*37 + i*11 + 3) & 255);
        xact(5'(i), v, 1'b1, 1'b0);
        model[p][i] = v;
      end
      chkflat("R4 R7 flat after page writes");
      for (int i = 0; i < NR; i++) begin
        xact(5'(i), 8'h00, 1'b0, 1'b1);
        chk8("R5 written read", rd_data, model[p][i]);
      end
    end

    // R3: every illegal selector value
    xact(5'h1F, 8'd3, 1'b1, 1'b0);
    mpage = 3;
    for (int w = NP; w < 256; w++) begin
      xact(5'h1F, 8'(w), 1'b1, 1'b0);
      xact(5'h1F, 8'h00, 1'b0, 1'b1);
      chk8("R3 illegal page ignored", rd_data, 8'(mpage));
    end
    xact(5'h02, 8'hC3, 1'b1, 1'b0);
    model[3][2] = 8'hC3;
    chkflat("R3 write lands in kept page");

    // R6: unimplemented slots
    xact(5'h1F, 8'd2, 1'b1, 1'b0);
    mpage = 2;
    for (int a = NR; a < 31; a++) begin
      xact(5'(a), 8'hFF, 1'b1, 1'b0);
      chkflat("R6 unimplemented write no effect");
      xact(5'(a), 8'h00, 1'b0, 1'b1);
      chk8("R6 unimplemented read zero", rd_data, 8'h00);
    end

    // R8: hold while no read
    xact(5'h05, 8'h00, 1'b0, 1'b1);
    hold = model[2][5];
    chk8("R8 setup read", rd_data, hold);
    for (int k = 0; k < 8; k++) begin
      xact(5'(k), 8'(k), 1'b0, 1'b0);
      chk8("R8 rd_data held", rd_data, hold);
    end
    chkflat("R8 idle no writes");

    // R9: read and write to the same address together
    xact(5'h07, 8'h96, 1'b1, 1'b1);
    chk8("R9 read returns old", rd_data, model[2][7]);
    model[2][7] = 8'h96;
    xact(5'h07, 8'h00, 1'b0, 1'b1);
    chk8("R9 new value after", rd_data, 8'h96);

    // R10: reset mid-run
    apply_reset();
    chk8("R10 rd_data cleared", rd_data, 8'h00);
    chkflat("R10 defaults restored");
    xact(5'h1F, 8'h00, 1'b0, 1'b1);
    chk8("R10 page zero", rd_data, 8'h00);
    xact(5'h03, 8'h00, 1'b0, 1'b1);
    chk8("R10 page0 default read", rd_data, dflt(0, 3));

    done = 1'b1;
    finish_run();
  end
endmodule